// File: doc/BRIEF.md
# Daisy-Chained TDM Serial Output Port

This block is the serial output stage of one multi-channel converter node. Identical nodes are wired in a chain: each node's serial data and frame-sync outputs feed the next node's serial inputs, and the last node in the chain feeds the host. All nodes run on the same serial clock (`clk`) and all receive the same `frame_start` pulse at the start of a sample period. On that pulse each node captures its six 16-bit channel results and its channel enables. It then sends one word per enabled channel. Between its own words, it passes on the words that arrive from upstream.

The host receives the words grouped by channel. Within each group, the node nearest the host comes first and node 1 comes last. Each node works out its own launch slot and the group length from the programmed chain length and its own position. Every word lands on the host line directly after the one before it, and groups are exactly one cycle longer than the words they carry. Channels switched off are skipped by every node in the same way, so the enable vector must be the same across the chain.

Top module: `tdm_chain_node`

## Requirements
- R1: While `rst_n` is low, and after it, until a sample period starts, `sdo` and `sdo_fs` are low.
- R2: A word is 16 bits, driven MSB first. Channel c (0-based, enable bit `ch_en[c]`) takes its word from `sample_bus[16c+15:16c]`. Samples and enables are captured on the cycle `frame_start` is accepted.
- R3: On the host line, channel groups come in ascending channel order. Inside a group the words arrive from node `chain_len` down to node 1, back to back, one word every 16 cycles.
- R4: Each word a node originates is preceded by exactly one cycle of its own frame sync. Each node sends one word per enabled channel per sample period, so the host sees `chain_len` × (enabled channels) frame syncs.
- R5: A channel group lasts exactly 16·`chain_len`+1 cycles, for every chain length. The next group's first frame sync follows the previous group's last data bit directly.
- R6: Outside its own data window, a node drives `sdo` with `sdi` delayed by one cycle. Outside its own frame-sync cycle, it drives `sdo_fs` with `sdi_fs` delayed by one cycle.
- R7: Node `node_pos` = p (1..`chain_len`; p = `chain_len` is the node next to the host) raises its own frame sync (N−p)·15 cycles into each group on its output, where N = `chain_len`.
- R8: A disabled channel takes no group; the next enabled channel's group follows at once.
- R9: A `frame_start` with no channel enabled starts nothing, and the outputs only relay.
- R10: A `frame_start` during a sample period is ignored. Changes on `sample_bus` or `ch_en` after capture do not alter the words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that starts a sample period |
| chain_len | input | 4 | Number of nodes in the chain, 1..8 |
| node_pos | input | 4 | Position of this node, 1..chain_len |
| ch_en | input | 6 | Channel enables, bit c for channel c |
| sample_bus | input | 96 | Six 16-bit channel results, channel c at bits 16c+15:16c |
| sdi | input | 1 | Serial data from the upstream node |
| sdi_fs | input | 1 | Frame sync from the upstream node |
| sdo | output | 1 | Serial data toward host or downstream node |
| sdo_fs | output | 1 | Frame sync toward host or downstream node |

## Verification
Two events share a cycle on each node, and this is where timing errors would appear. A node's own last data bit goes out in the same cycle as the relayed frame sync of the upstream node's word, so data and frame sync must be switched between own and relay sources independently. The bench drives chains of one to four nodes and compares the host line bit by bit against a behavioural stream. Any overlap error shows up as a shifted or missing sync. The second collision is a `frame_start` that arrives in the middle of a group while new sample values are presented. The bench requires the stream to continue unchanged.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

  // Cycles in one channel group: every node's word plus one sync cycle.
  function automatic int unsigned group_len(input int unsigned word_w,
                                            input int unsigned nodes);
    return word_w * nodes + 1;
  endfunction

  // Group cycle where a node raises its own frame sync. Each relay hop adds
  // one register, so upstream nodes launch one cycle less than a word apart.
  function automatic int unsigned own_offset(input int unsigned word_w,
                                             input int unsigned nodes,
                                             input int unsigned pos);
    return (nodes - pos) * (word_w - 1);
  endfunction

  // First enabled channel at or after 'from'; n_ch when none is left.
  function automatic int unsigned next_enabled(input logic [31:0] en,
                                               input int unsigned from,
                                               input int unsigned n_ch);
    for (int unsigned j = from; j < n_ch; j++) begin
      if (en[j]) return j;
    end
    return n_ch;
  endfunction

endpackage

// File: rtl/tdm_seq_ctrl.sv
module tdm_seq_ctrl
  import tdm_chain_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CW     = 8,
  parameter int unsigned NW     = 4,
  parameter int unsigned CHW    = 3,
  parameter int unsigned BW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NW-1:0]     chain_len,
  input  logic [NW-1:0]     node_pos,
  output logic              capture,
  output logic              own_fs,
  output logic              own_dat,
  output logic [CHW-1:0]    ch_idx,
  output logic [BW-1:0]     bit_idx
);

  logic              busy;
  logic [CW-1:0]     cnt;
  logic [NUM_CH-1:0] en_q;
  logic [CW-1:0]     glen;
  logic [CW-1:0]     ofs;
  logic [CHW-1:0]    first_ch;
  logic [CHW-1:0]    nxt_ch;
  logic              grp_end;

  always_comb begin
    glen     = CW'(group_len(WORD_W, 32'(chain_len)));
    ofs      = CW'(own_offset(WORD_W, 32'(chain_len), 32'(node_pos)));
    first_ch = CHW'(next_enabled(32'(ch_en), 0, NUM_CH));
    nxt_ch   = CHW'(next_enabled(32'(en_q), 32'(ch_idx) + 1, NUM_CH));
    capture  = frame_start && !busy && (first_ch != CHW'(NUM_CH));
    grp_end  = busy && (cnt == glen - CW'(1));
    own_fs   = busy && (cnt == ofs);
    own_dat  = busy && (cnt > ofs) && (cnt <= ofs + CW'(WORD_W));
    bit_idx  = BW'(ofs + CW'(WORD_W) - cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      ch_idx <= '0;
      en_q   <= '0;
    end else if (capture) begin
      busy   <= 1'b1;
      cnt    <= '0;
      ch_idx <= first_ch;
      en_q   <= ch_en;
    end else if (busy) begin
      if (grp_end) begin
        cnt <= '0;
        if (nxt_ch == CHW'(NUM_CH)) busy <= 1'b0;
        else                       ch_idx <= nxt_ch;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R10: a start pulse inside a sample period does not restart the count
  a_r10_start_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_start && !grp_end) |=> (cnt == $past(cnt) + CW'(1)));

  // R8: the channel being served is always one that was enabled at capture
  a_r8_served_channel_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en_q[ch_idx]);

  // R5: the group counter never passes the group length
  a_r5_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < glen));

  // R4: own frame sync is followed by the first own data bit
  a_r4_sync_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    own_fs |=> own_dat);

endmodule

// File: rtl/tdm_word_sel.sv
module tdm_word_sel #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CHW    = 3,
  parameter int unsigned BW     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [NUM_CH*WORD_W-1:0] sample_bus,
  input  logic [CHW-1:0]           ch_idx,
  input  logic [BW-1:0]            bit_idx,
  output logic                     own_bit
);

  logic [NUM_CH-1:0][WORD_W-1:0] hold;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold[c] <= '0;
      else if (capture) hold[c] <= sample_bus[c*WORD_W +: WORD_W];
    end
  end

  assign own_bit = hold[ch_idx][bit_idx];

endmodule

// File: rtl/tdm_out_stage.sv
module tdm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic own_fs,
  input  logic own_dat,
  input  logic own_bit,
  input  logic sdi,
  input  logic sdi_fs,
  output logic sdo,
  output logic sdo_fs
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo    <= 1'b0;
      sdo_fs <= 1'b0;
    end else begin
      sdo    <= own_dat ? own_bit : sdi;
      sdo_fs <= own_fs  ? 1'b1    : sdi_fs;
    end
  end

  // R6: relay path on data, one register late
  a_r6_relay_data: assert property (@(posedge clk) disable iff (!rst_n)
    !own_dat |=> (sdo == $past(sdi)));

  // R6: relay path on frame sync, one register late
  a_r6_relay_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !own_fs |=> (sdo_fs == $past(sdi_fs)));

  // R4: own frame sync reaches the output pin
  a_r4_own_sync_out: assert property (@(posedge clk) disable iff (!rst_n)
    own_fs |=> sdo_fs);

endmodule

// File: rtl/tdm_chain_node.sv
module tdm_chain_node #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_CH    = 6,
  parameter int unsigned MAX_NODES = 8,
  localparam int unsigned NW  = $clog2(MAX_NODES + 1),
  localparam int unsigned CW  = $clog2(WORD_W * MAX_NODES + 2),
  localparam int unsigned CHW = $clog2(NUM_CH + 1),
  localparam int unsigned BW  = $clog2(WORD_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic [NW-1:0]            chain_len,
  input  logic [NW-1:0]            node_pos,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH*WORD_W-1:0] sample_bus,
  input  logic                     sdi,
  input  logic                     sdi_fs,
  output logic                     sdo,
  output logic                     sdo_fs
);

  logic           capture;
  logic           own_fs;
  logic           own_dat;
  logic           own_bit;
  logic [CHW-1:0] ch_idx;
  logic [BW-1:0]  bit_idx;

  tdm_seq_ctrl #(
    .WORD_W(WORD_W), .NUM_CH(NUM_CH), .CW(CW), .NW(NW), .CHW(CHW), .BW(BW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_en(ch_en),
    .chain_len(chain_len), .node_pos(node_pos), .capture(capture),
    .own_fs(own_fs), .own_dat(own_dat), .ch_idx(ch_idx), .bit_idx(bit_idx)
  );

  tdm_word_sel #(
    .WORD_W(WORD_W), .NUM_CH(NUM_CH), .CHW(CHW), .BW(BW)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .capture(capture), .sample_bus(sample_bus),
    .ch_idx(ch_idx), .bit_idx(bit_idx), .own_bit(own_bit)
  );

  tdm_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .own_fs(own_fs), .own_dat(own_dat),
    .own_bit(own_bit), .sdi(sdi), .sdi_fs(sdi_fs), .sdo(sdo), .sdo_fs(sdo_fs)
  );

  // R4: a node never has its sync and data windows at once
  a_r4_windows_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(own_fs && own_dat));

endmodule

// File: tb/tdm_chain_node_tb.sv
module tdm_chain_node_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NN-1:0] start = '0;
  logic [3:0] cl;
  logic [5:0] en = '0;
  logic [95:0] smp [NN];
  logic [NN:0] dv, fv;
  logic host_d, host_f;
  int n_len = 1;
  int vec = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cl = 4'(n_len);
  assign dv[0] = 1'b0;
  assign fv[0] = 1'b0;

  for (genvar k = 0; k < NN; k++) begin : g_node
    tdm_chain_node u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(start[k]), .chain_len(cl),
      .node_pos(4'(k + 1)), .ch_en(en), .sample_bus(smp[k]),
      .sdi(dv[k]), .sdi_fs(fv[k]), .sdo(dv[k+1]), .sdo_fs(fv[k+1])
    );
  end

  assign host_d = dv[n_len];
  assign host_f = fv[n_len];

  function automatic logic [15:0] val(input int p, input int c, input int seed);
    return 16'((seed * 32'h3D7) ^ (p << 12) ^ (c * 32'h0911) ^ 32'h8001);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic run(input int n, input logic [5:0] e, input int seed, input bit inject);
    int g, ng, len, base, gi, fcnt;
    int ed[$];
    int ef[$];
    logic [15:0] w;
    logic [NN:0] pd;
    logic [NN-1:0] mask;
    ng = 0;
    for (int c = 0; c < 6; c++) if (e[c]) ng++;
    g = 16 * n + 1;
    len = ng * g + 24;
    n_len = n;
    en = e;
    mask = '0;
    for (int k = 0; k < n; k++) mask[k] = 1'b1;
    for (int p = 1; p <= NN; p++)
      for (int c = 0; c < 6; c++) smp[p-1][c*16 +: 16] = val(p, c, seed);
    ed.delete();
    ef.delete();
    for (int t = 0; t < len; t++) begin ed.push_back(0); ef.push_back(0); end
    gi = 0;
    for (int c = 0; c < 6; c++) begin
      if (e[c]) begin
        for (int p = n; p >= 1; p--) begin
          base = gi * g + (n - p) * 16;
          ef[base] = 1;
          w = val(p, c, seed);
          for (int b = 0; b < 16; b++) ed[base + 1 + b] = int'(w[15 - b]);
        end
        gi++;
      end
    end
    @(negedge clk); start = mask;
    @(negedge clk); start = '0;
    pd = dv;
    fcnt = 0;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      // R2 R3 R5 R8 R9: host line matches the behavioural stream
      check(host_d === 1'(ed[t]) && host_f === 1'(ef[t]), "R2 R3 R5 R8 R9 host stream",
            int'({host_f, host_d}), (ef[t] << 1) | ed[t]);
      if (host_f === 1'b1) fcnt++;
      // R7: each node's own sync offset in the first group
      for (int p = 1; p <= n; p++)
        if (ng > 0 && t == (n - p) * 15)
          check(fv[p] === 1'b1, "R7 own sync offset", int'(fv[p]), 1);
      // R6: node next to host relays upstream data one cycle late
      if (ng > 0 && n >= 2 && t >= 17 && t <= 16 * n)
        check(host_d === pd[n-1], "R6 relay delay", int'(host_d), int'(pd[n-1]));
      pd = dv;
      if (inject && t == 40) begin
        start = mask;
        en = ~e;
        for (int p = 1; p <= NN; p++)
          for (int c = 0; c < 6; c++) smp[p-1][c*16 +: 16] = val(p, c, seed + 99);
      end
      if (inject && t == 41) start = '0;
    end
    // R4: one sync per node per enabled channel
    check(fcnt == n * ng, "R4 sync count", fcnt, n * ng);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NN; k++) smp[k] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check(dv[NN:1] === '0 && fv[NN:1] === '0, "R1 reset outputs", int'(dv), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dv[NN:1] === '0 && fv[NN:1] === '0, "R1 idle after reset", int'(fv), 0);
    run(1, 6'b111111, 1, 1'b0);   // R2 R4 single node
    run(2, 6'b111111, 2, 1'b0);   // R3 R5 R6 two nodes
    run(3, 6'b101101, 3, 1'b0);   // R8 gaps in enables
    run(4, 6'b111111, 4, 1'b1);   // R10 restart and data change mid-period
    run(3, 6'b000000, 5, 1'b0);   // R9 nothing enabled
    run(4, 6'b100000, 6, 1'b0);   // R8 only the last channel
    run(2, 6'b000011, 7, 1'b1);   // R10 short period with injection
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule